// File: doc/BRIEF.md
# Split-Register Modulo-Six Up/Down Counter

This block counts through six values, 0 to 5, stepping up or down one value per clock on request and wrapping at both ends. The count is not held in one 3-bit register. It is held by two small state machines with a 2-bit register each. The lower machine holds counts 0, 1 and 2 and has one parking state. The upper machine holds counts 3, 4 and 5 and has its own parking state. In every cycle, one machine holds the live count and the other waits in its parking state.

When the count crosses the 2/3 boundary or wraps between 5 and 0, the active machine moves into its parking state. On that same clock edge, its partner leaves parking. It enters the count that the crossing calls for, and it does so only because it sees the active machine's state together with the step request. The combined count is rebuilt from whichever machine is active. Both raw state registers are also brought out, so the handoff can be observed.

Top module: `split_mod6_counter`

## Requirements
- R1: A synchronous reset places the lower machine in code 0 and the upper machine in its parking code 3, so the count reads 0.
- R2: With `step_up` high, the count advances by one on each clock edge, and 5 wraps to 0.
- R3: With only `step_down` high, the count drops by one on each clock edge, and 0 wraps to 5.
- R4: With neither request high, the count and both state codes stay unchanged.
- R5: When both requests are high, the up step wins in both machines.
- R6: In every cycle after reset, exactly one of the two machines holds the parking code 3.
- R7: A crossing happens on one edge: in the cycle where one machine enters parking, its partner leaves parking.
- R8: State codes: the lower machine shows code = count when count < 3, otherwise 3. The upper machine shows code = count − 3 when count ≥ 3, otherwise 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_up | input | 1 | Request to count up one value |
| step_down | input | 1 | Request to count down one value |
| count_o | output | 3 | Combined count, 0 to 5 |
| low_state_o | output | 2 | Lower machine state code |
| high_state_o | output | 2 | Upper machine state code |

## Verification
The bench starts from each of the six counts and applies every one of the four request patterns. This covers both wraps and both boundary crossings in both directions. If a design forgot the partner qualification on leaving parking, both machines would go active together, or both would sit parked. If the two machines resolved simultaneous requests differently, one would step up while the other stepped down, which would break the single-parked rule. A long pseudo-random run then compares the count and both state codes each cycle with an arithmetic mod-6 model. This catches drifted codes, lost holds and missed wraps.

// File: rtl/split_ctr_pkg.sv
package split_ctr_pkg;
  localparam int CODE_W   = 2;
  localparam int HALF_CNT = 3;
  localparam int TOTAL    = 2 * HALF_CNT;
  localparam int COUNT_W  = $clog2(TOTAL);

  localparam logic [CODE_W-1:0] POS_FIRST = 2'd0;
  localparam logic [CODE_W-1:0] POS_MID   = 2'd1;
  localparam logic [CODE_W-1:0] POS_LAST  = 2'd2;
  localparam logic [CODE_W-1:0] PARKED    = 2'd3;
endpackage

// File: rtl/split_ctr_cmd.sv
module split_ctr_cmd (
  input  logic up_req,
  input  logic dn_req,
  output logic up_step,
  output logic dn_step
);
  // single priority rule shared by both halves: up wins
  always_comb begin
    up_step = up_req;
    dn_step = dn_req & ~up_req;
  end
endmodule

// File: rtl/split_ctr_half.sv
module split_ctr_half
  import split_ctr_pkg::*;
#(
  parameter bit START_PARKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_step,
  input  logic              dn_step,
  input  logic [CODE_W-1:0] partner,
  output logic [CODE_W-1:0] state_o
);
  logic [CODE_W-1:0] state_q, state_d;
  logic [CODE_W-1:0] reset_code;

  generate
    if (START_PARKED) begin : g_rst_parked
      assign reset_code = PARKED;
    end else begin : g_rst_active
      assign reset_code = POS_FIRST;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      POS_FIRST: begin
        if (up_step)      state_d = POS_MID;
        else if (dn_step) state_d = PARKED;
      end
      POS_MID: begin
        if (up_step)      state_d = POS_LAST;
        else if (dn_step) state_d = POS_FIRST;
      end
      POS_LAST: begin
        if (up_step)      state_d = PARKED;
        else if (dn_step) state_d = POS_MID;
      end
      default: begin
        // leave parking only when the partner is leaving toward us
        if (up_step && partner == POS_LAST)       state_d = POS_FIRST;
        else if (dn_step && partner == POS_FIRST) state_d = POS_LAST;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= reset_code;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  AST_UP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (up_step && (state_q == POS_FIRST || state_q == POS_MID)) |=> (state_q == $past(state_q) + 2'd1)); // R2
  AST_DN_RETREAT: assert property (@(posedge clk) disable iff (rst)
    (dn_step && (state_q == POS_MID || state_q == POS_LAST)) |=> (state_q == $past(state_q) - 2'd1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!up_step && !dn_step) |=> $stable(state_q)); // R4
  AST_PARK_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == PARKED && partner == POS_MID) |=> (state_q == PARKED)); // R6
endmodule

// File: rtl/split_ctr_merge.sv
module split_ctr_merge
  import split_ctr_pkg::*;
(
  input  logic [CODE_W-1:0]  low_code,
  input  logic [CODE_W-1:0]  high_code,
  output logic [COUNT_W-1:0] count
);
  always_comb begin
    if (low_code != PARKED) count = COUNT_W'(low_code);
    else                    count = COUNT_W'(high_code) + COUNT_W'(HALF_CNT);
  end
endmodule

// File: rtl/split_mod6_counter.sv
module split_mod6_counter
  import split_ctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_up,
  input  logic       step_down,
  output logic [2:0] count_o,
  output logic [1:0] low_state_o,
  output logic [1:0] high_state_o
);
  logic up_step, dn_step;
  logic [CODE_W-1:0] low_code, high_code;
  logic [COUNT_W-1:0] count;

  split_ctr_cmd u_cmd (
    .up_req (step_up),
    .dn_req (step_down),
    .up_step(up_step),
    .dn_step(dn_step)
  );

  split_ctr_half #(.START_PARKED(1'b0)) u_low (
    .clk    (clk),
    .rst    (rst),
    .up_step(up_step),
    .dn_step(dn_step),
    .partner(high_code),
    .state_o(low_code)
  );

  split_ctr_half #(.START_PARKED(1'b1)) u_high (
    .clk    (clk),
    .rst    (rst),
    .up_step(up_step),
    .dn_step(dn_step),
    .partner(low_code),
    .state_o(high_code)
  );

  split_ctr_merge u_merge (
    .low_code (low_code),
    .high_code(high_code),
    .count    (count)
  );

  assign count_o      = count;
  assign low_state_o  = low_code;
  assign high_state_o = high_code;

  AST_ONE_PARKED: assert property (@(posedge clk) disable iff (rst)
    ((low_code == PARKED) != (high_code == PARKED))); // R6
  AST_HANDOFF_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(low_code == PARKED) |-> $fell(high_code == PARKED)); // R7
  AST_HANDOFF_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(high_code == PARKED) |-> $fell(low_code == PARKED)); // R7
  AST_UP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (step_up && step_down) |=>
      (count == (($past(count) == 3'd5) ? 3'd0 : $past(count) + 3'd1))); // R5
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!step_up && step_down && count == 3'd0) |=> (count == 3'd5)); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (count <= 3'd5)); // R8
endmodule

// File: tb/split_mod6_counter_bench.sv
`timescale 1ns/1ps
module split_mod6_counter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_up = 1'b0, step_down = 1'b0;
  logic [2:0] count_o;
  logic [1:0] low_state_o, high_state_o;
  int checks = 0, failures = 0;
  int model = 0;
  int seed = 32'h1f2e3d4c;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  split_mod6_counter u_split_mod6_counter (
    .clk(clk), .rst(rst), .step_up(step_up), .step_down(step_down),
    .count_o(count_o), .low_state_o(low_state_o), .high_state_o(high_state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, int'(count_o), model);
    chk({req, "/R8 low"}, int'(low_state_o), (model < 3) ? model : 3);
    chk({req, "/R8 high"}, int'(high_state_o), (model >= 3) ? model - 3 : 3);
    chk("R6", int'((low_state_o == 2'd3) + (high_state_o == 2'd3)), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_up = 1'b0; step_down = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model = 0;
  endtask

  task automatic step(input logic u, input logic d, input string req);
    int prev_low;
    prev_low = int'(low_state_o);
    step_up = u; step_down = d;
    @(posedge clk); @(negedge clk);
    if (u)      model = (model + 1) % 6;
    else if (d) model = (model + 5) % 6;
    step_up = 1'b0; step_down = 1'b0;
    check_all(req);
    // R7: a change in parking status of one half implies the other changed too
    if ((prev_low == 3) != (low_state_o == 2'd3))
      chk("R7", int'((low_state_o == 2'd3) != (high_state_o == 2'd3)), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_all("R1");

    // sweep: every start count, every request pattern
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 4; p++) begin
        do_reset();
        for (int k = 0; k < s; k++) step(1'b1, 1'b0, "R2");
        case (p)
          0: step(1'b0, 1'b0, "R4");
          1: step(1'b1, 1'b0, "R2");
          2: step(1'b0, 1'b1, "R3");
          default: step(1'b1, 1'b1, "R5");
        endcase
      end
    end

    // repeated holds keep state
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "R2");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R4");

    // full down loop through the 0 -> 5 wrap
    do_reset();
    for (int k = 0; k < 13; k++) step(1'b0, 1'b1, "R3");

    // pseudo-random run against the model
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom(seed) % 4;
      seed = seed + 7919;
      step(r[0], r[1], (r == 3) ? "R5" : (r == 1) ? "R2" : (r == 2) ? "R3" : "R4");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule